// File: doc/BRIEF.md
# IDE PIO Cycle Timing Encoder

This block converts three per-drive bus-clock counts (address setup, active strobe, recovery) into the two timing bytes that an IDE host controller keeps for each register pair, and writes them into its own small timing register file. Four drives map onto three register pairs. Drive 0 and drive 1 each own a pair. Drives 2 and 3 share the third pair, so a value programmed there has to satisfy both drives.

A one-cycle `start` pulse captures a drive index, the three counts and a flag that says whether that drive's partner is present. The block then writes the setup byte and then the data-timing byte, one per cycle. It raises `done` for one cycle after the second write. The block remembers the counts last programmed for every drive, so a shared-pair write can take the larger of the two drives' needs without extra inputs. The low six bits of each setup register belong to other functions. Only a separate control write port changes them, and a timing write leaves them as they are. A combinational read port shows any pair's current contents.

Top module: `ide_pio_timing_encoder`

## Requirements
- R1: The setup count maps into bits 7:6 of the setup byte as follows: 4 gives 2'b00, 3 gives 2'b10, 1 or 2 gives 2'b01, and every other value (0, 5 and above) gives 2'b11.
- R2: A timing write replaces only bits 7:6 of the target setup register. Bits 5:0 keep their value, and only a control write (`ctl_wr`, pair `ctl_sel`, value `ctl_bits`) changes them.
- R3: The data-timing byte holds the low four bits of the active count in bits 7:4 and the low four bits of the recovery count in bits 3:0. A count of 16 therefore packs as 0.
- R4: Drive 0 writes pair 0 and drive 1 writes pair 1, always using their own counts, whatever `peer_present` says. Drives 2 and 3 both write pair 2. Read select value 3 also reads pair 2.
- R5: For drive 2 or 3 with `peer_present` high, each of setup, active and recovery is raised to the partner's (index XOR 1) stored count when that count is larger. With `peer_present` low, no raising takes place.
- R6: After reset every drive's stored counts are setup 4, active 16 and recovery 16, and every pair reads setup byte 0x00 and data byte 0x00. Each accepted start stores the drive's own counts, before any raising.
- R7: An accepted start in cycle k writes the setup register at the end of cycle k+1 and the data register at the end of cycle k+2. `done` is high in cycle k+3 only.
- R8: A start that arrives while a sequence is in progress is ignored. It leaves the register file, the stored counts and the output bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one timing write |
| drv_idx | input | 2 | Drive index 0..3 |
| setup_cnt | input | CW | Address setup count in clocks |
| active_cnt | input | CW | Active strobe count in clocks |
| recov_cnt | input | CW | Recovery count in clocks |
| peer_present | input | 1 | Partner drive of a shared pair is present |
| ctl_wr | input | 1 | Write low six bits of a setup register |
| ctl_sel | input | 2 | Pair for the control write (3 selects pair 2) |
| ctl_bits | input | 6 | Value for bits 5:0 |
| rd_sel | input | 2 | Pair shown on the read port (3 selects pair 2) |
| rd_setup | output | 8 | Setup register of the selected pair |
| rd_data | output | 8 | Data-timing register of the selected pair |
| setup_byte | output | 8 | Setup byte of the latest accepted write |
| data_byte | output | 8 | Data-timing byte of the latest accepted write |
| done | output | 1 | One-cycle completion pulse |

## Verification
Drive 0 is swept over every setup count 0..7 and every active and recovery count 0..31. This separates the four setup codes and exposes any error in nibble truncation or ordering, including the wrap of 16 to 0. For the shared pair, drive 3 and drive 2 are programmed with counts on both sides of each other, with the partner flag both set and clear. This tells field-wise maximum apart from whole-set copying and from merging when no partner is present. Dedicated sequences preset the low setup bits, send a start while the block is busy, and program drive 1 with the partner flag set, to show that drives 0 and 1 never merge.

// File: rtl/ide_pio_timing_encoder.sv
module ide_pio_timing_encoder #(
  parameter int CW        = 5,
  parameter int DEF_SETUP = 4,
  parameter int DEF_ACT   = 16,
  parameter int DEF_REC   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    drv_idx,
  input  logic [CW-1:0] setup_cnt,
  input  logic [CW-1:0] active_cnt,
  input  logic [CW-1:0] recov_cnt,
  input  logic          peer_present,
  input  logic          ctl_wr,
  input  logic [1:0]    ctl_sel,
  input  logic [5:0]    ctl_bits,
  input  logic [1:0]    rd_sel,
  output logic [7:0]    rd_setup,
  output logic [7:0]    rd_data,
  output logic [7:0]    setup_byte,
  output logic [7:0]    data_byte,
  output logic          done
);

  localparam int NDRV  = 4;
  localparam int NPAIR = 3;
  localparam logic [CW-1:0] D_S = CW'(DEF_SETUP);
  localparam logic [CW-1:0] D_A = CW'(DEF_ACT);
  localparam logic [CW-1:0] D_R = CW'(DEF_REC);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_DATA, S_DONE} state_t;

  function automatic logic [1:0] enc_setup(input logic [CW-1:0] c);
    if (c == CW'(4))                      return 2'b00;
    else if (c == CW'(3))                 return 2'b10;
    else if (c == CW'(1) || c == CW'(2))  return 2'b01;
    else                                  return 2'b11;
  endfunction

  function automatic logic [1:0] pair_of(input logic [1:0] sel);
    return sel[1] ? 2'd2 : {1'b0, sel[0]};
  endfunction

  function automatic logic [CW-1:0] maxc(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (b > a) ? b : a;
  endfunction

  localparam logic [1:0] RST_HI  = enc_setup(D_S);
  localparam logic [7:0] RST_DAT = {D_A[3:0], D_R[3:0]};

  state_t state;
  logic          busy;
  logic [1:0]    pair_q;
  logic [1:0]    hi_q;
  logic [7:0]    dat_q;

  logic [CW-1:0] st_s [NDRV];
  logic [CW-1:0] st_a [NDRV];
  logic [CW-1:0] st_r [NDRV];

  logic [1:0]    reg_hi  [NPAIR];
  logic [5:0]    reg_lo  [NPAIR];
  logic [7:0]    reg_dat [NPAIR];

  logic [1:0]    mate;
  logic          merge;
  logic [CW-1:0] m_s, m_a, m_r;

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign mate  = drv_idx ^ 2'd1;
  assign merge = drv_idx[1] & peer_present;
  assign m_s   = merge ? maxc(setup_cnt,  st_s[mate]) : setup_cnt;
  assign m_a   = merge ? maxc(active_cnt, st_a[mate]) : active_cnt;
  assign m_r   = merge ? maxc(recov_cnt,  st_r[mate]) : recov_cnt;

  assign setup_byte = {hi_q, reg_lo[pair_q]};
  assign data_byte  = dat_q;
  assign rd_setup   = {reg_hi[pair_of(rd_sel)], reg_lo[pair_of(rd_sel)]};
  assign rd_data    = reg_dat[pair_of(rd_sel)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pair_q <= 2'd0;
      hi_q   <= RST_HI;
      dat_q  <= RST_DAT;
      for (int i = 0; i < NDRV; i++) begin
        st_s[i] <= D_S;
        st_a[i] <= D_A;
        st_r[i] <= D_R;
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state         <= S_SETUP;
          pair_q        <= pair_of(drv_idx);
          hi_q          <= enc_setup(m_s);
          dat_q         <= {m_a[3:0], m_r[3:0]};
          st_s[drv_idx] <= setup_cnt;
          st_a[drv_idx] <= active_cnt;
          st_r[drv_idx] <= recov_cnt;
        end
        S_SETUP: state <= S_DATA;
        S_DATA:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAIR; p++) begin
        reg_hi[p]  <= RST_HI;
        reg_lo[p]  <= 6'd0;
        reg_dat[p] <= RST_DAT;
      end
    end else begin
      if (state == S_SETUP) reg_hi[pair_q]  <= hi_q;
      if (state == S_DATA)  reg_dat[pair_q] <= dat_q;
      if (ctl_wr)           reg_lo[pair_of(ctl_sel)] <= ctl_bits;
    end
  end

endmodule

// File: rtl/ide_pio_timing_encoder_chk.sv
module ide_pio_timing_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       ctl_wr,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_setup,
  input logic [7:0] setup_byte,
  input logic [7:0] data_byte,
  input logic       done
);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ##2 done);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(data_byte) && $stable(setup_byte[7:6])));

  a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> (rd_sel != $past(rd_sel)) || (rd_setup[5:0] == $past(rd_setup[5:0])));

endmodule

bind ide_pio_timing_encoder ide_pio_timing_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .ctl_wr     (ctl_wr),
  .rd_sel     (rd_sel),
  .rd_setup   (rd_setup),
  .setup_byte (setup_byte),
  .data_byte  (data_byte),
  .done       (done)
);

// File: tb/test_ide_pio_timing_encoder.sv
module test_ide_pio_timing_encoder;
  localparam int CW = 5;
  localparam time TCLK = 10;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [1:0]    drv_idx = 0;
  logic [CW-1:0] setup_cnt = 0, active_cnt = 0, recov_cnt = 0;
  logic          peer_present = 0;
  logic          ctl_wr = 0;
  logic [1:0]    ctl_sel = 0;
  logic [5:0]    ctl_bits = 0;
  logic [1:0]    rd_sel = 0;
  logic [7:0]    rd_setup, rd_data, setup_byte, data_byte;
  logic          done;

  int n_tests = 0;
  int n_fail  = 0;

  int ms [4];
  int ma [4];
  int mr [4];
  logic [5:0] mlo [3];
  logic [1:0] mhi [3];
  logic [7:0] mdat [3];

  always #(TCLK/2) clk = ~clk;

  ide_pio_timing_encoder #(.CW(CW)) i_ide_pio_timing_encoder (
    .clk, .rst_n, .start, .drv_idx, .setup_cnt, .active_cnt, .recov_cnt,
    .peer_present, .ctl_wr, .ctl_sel, .ctl_bits, .rd_sel,
    .rd_setup, .rd_data, .setup_byte, .data_byte, .done
  );

  function automatic logic [1:0] code(input int c);
    if (c == 4) return 2'b00;
    if (c == 3) return 2'b10;
    if (c == 1 || c == 2) return 2'b01;
    return 2'b11;
  endfunction

  function automatic int pair(input int i);
    return (i >= 2) ? 2 : i;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic show(input int p);
    @(negedge clk);
    rd_sel = 2'(p);
    #1;
  endtask

  task automatic ctl(input int p, input logic [5:0] v);
    @(negedge clk);
    ctl_wr = 1; ctl_sel = 2'(p); ctl_bits = v;
    @(negedge clk);
    ctl_wr = 0;
    mlo[pair(p)] = v;
  endtask

  task automatic prog(input int idx, input int s, input int a, input int r,
                      input bit pp, input bit full);
    int es, ea, er, p, m;
    p = pair(idx);
    m = idx ^ 1;
    es = s; ea = a; er = r;
    if (idx >= 2 && pp) begin
      if (ms[m] > es) es = ms[m];
      if (ma[m] > ea) ea = ma[m];
      if (mr[m] > er) er = mr[m];
    end
    ms[idx] = s; ma[idx] = a; mr[idx] = r;
    mhi[p] = code(es);
    mdat[p] = {4'(ea), 4'(er)};
    @(negedge clk);
    drv_idx = 2'(idx); setup_cnt = CW'(s); active_cnt = CW'(a); recov_cnt = CW'(r);
    peer_present = pp; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    if (full) chk("R7 done low mid-sequence", {7'd0, done}, 8'd0);
    @(negedge clk);
    chk("R7 done pulse", {7'd0, done}, 8'd1);
    rd_sel = 2'(p);
    #1;
    chk("R1 R2 setup register", rd_setup, {mhi[p], mlo[p]});
    chk("R3 data register", rd_data, mdat[p]);
    if (full) begin
      chk("R1 setup_byte", setup_byte, {mhi[p], mlo[p]});
      chk("R3 data_byte", data_byte, mdat[p]);
    end
    @(negedge clk);
    if (full) chk("R7 done single cycle", {7'd0, done}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ms[i] = 4; ma[i] = 16; mr[i] = 16; end
    for (int p = 0; p < 3; p++) begin mlo[p] = 0; mhi[p] = 2'b00; mdat[p] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R6 reset state of every pair
    for (int p = 0; p < 4; p++) begin
      show(p);
      chk("R6 reset setup", rd_setup, 8'h00);
      chk("R6 reset data", rd_data, 8'h00);
    end
    chk("R6 done low after reset", {7'd0, done}, 8'd0);

    // R6 reset stored counts: drive 2 merged with untouched drive 3 (4/16/16)
    prog(2, 1, 2, 3, 1, 1);
    chk("R6 default mate counts used", rd_data, 8'h00);

    // R2 preset low bits, then timing writes keep them
    ctl(0, 6'h2A);
    ctl(1, 6'h15);
    ctl(3, 6'h33);

    // R1 R3 sweep on drive 0
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 32; a++)
        for (int r = 0; r < 32; r++)
          prog(0, s, a, r, 0, (a % 8 == 0));

    // R1 full setup range on drive 1, also R4 with peer flag set
    for (int s = 0; s < 32; s++) prog(1, s, 16, 1, 1, 1);
    prog(1, 2, 5, 6, 1, 1);
    show(1);
    chk("R4 drive 1 no merge", rd_data, 8'h56);
    chk("R4 drive 1 setup own", rd_setup, {2'b01, 6'h15});
    show(0);
    chk("R4 pair 0 untouched by drive 1", rd_data, mdat[0]);

    // R5 merge on shared pair
    for (int x = 0; x < 6; x++)
      for (int y = 0; y < 6; y++)
        for (int pp = 0; pp < 2; pp++) begin
          prog(3, x + 1, 3 * x + 1, 17 - 3 * x, 0, 1);
          prog(2, y + 1, 3 * y + 1, 16 - 2 * y, pp[0], 1);
        end
    prog(3, 6, 9, 2, 0, 1);
    prog(2, 1, 3, 8, 1, 1);
    show(2);
    chk("R5 field maxima", rd_setup, {2'b11, 6'h33});
    chk("R5 field maxima data", rd_data, 8'h98);
    prog(2, 1, 3, 8, 0, 1);
    show(3);
    chk("R5 no merge without peer", rd_data, 8'h38);
    chk("R4 select 3 reads pair 2 setup", rd_setup, {2'b01, 6'h33});

    // R8 start ignored while busy
    prog(0, 3, 7, 7, 0, 1);
    @(negedge clk);
    drv_idx = 2'd1; setup_cnt = 5'd4; active_cnt = 5'd2; recov_cnt = 5'd9; start = 1;
    @(negedge clk);
    drv_idx = 2'd0; setup_cnt = 5'd1; active_cnt = 5'd3; recov_cnt = 5'd4; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R8 done after first", {7'd0, done}, 8'd1);
    chk("R8 data_byte from accepted start", data_byte, 8'h29);
    @(negedge clk);
    rd_sel = 2'd0; #1;
    chk("R8 pair 0 unchanged", rd_data, 8'h77);
    chk("R8 pair 0 setup unchanged", rd_setup, {2'b10, 6'h2A});
    ms[1] = 4; ma[1] = 2; mr[1] = 9;
    mhi[1] = code(4); mdat[1] = 8'h29;
    show(1);
    chk("R8 accepted write landed", rd_data, 8'h29);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule